// File: doc/BRIEF.md
# Output Setpoint Slew Sequencer

This block walks a 6-bit regulator DAC code from its present value to a new target. Rising moves advance one code per step, with the step interval set by a 3-bit rate code. Each rate code waits half as many time-base ticks per step as the code below it. The all-ones rate code and every falling move go to the target in a single step. The time base is a prescaled tick input. The block never counts raw clocks between steps.

A move starts in one of two ways. In software mode it starts on a rising edge of the GO input. In hardware mode it starts when the selected setpoint input changes, and GO is ignored. While a move is running, busy is high. When the code reaches the target, a one-clock done pulse is produced. The register holding GO uses this pulse to clear itself. A new trigger during a ramp re-latches the target, and the ramp carries on from the present code.

Top module: `slew_sequencer`

## Requirements
- R1: After reset, dacCode is 0 and busy and done are both low.
- R2: With hwMode low, a 0-to-1 transition of goBit starts a move toward targetCode. A change of targetCode alone starts nothing.
- R3: With hwMode high, goBit has no effect, and any change of targetCode from its value in the previous cycle starts a move toward the new value.
- R4: For a rising move with slewCode r in 0..6, dacCode rises by exactly 1 after every 2^(6-r) tick cycles. With tick held high, done appears N*2^(6-r) clocks after the trigger edge, where N is the number of codes to climb.
- R5: A rising move with slewCode 7 (binary 111) loads the target at the trigger edge. Done follows in that same cycle and busy never goes high.
- R6: A falling move loads the target at the trigger edge for every slewCode, with done in that same cycle.
- R7: Done is one clock wide and asserts only when dacCode equals the latched target. Busy falls in the cycle done is high.
- R8: A trigger whose target equals dacCode gives done on the next clock, and dacCode does not change.
- R9: A rising trigger during a ramp re-latches the target without lowering dacCode or restarting the ramp. On that edge the tick count does not advance.
- R10: While busy, dacCode only holds or rises by 1, and it holds in any cycle where tick is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| targetCode | input | 6 | Selected setpoint code |
| slewCode | input | 3 | Rising-move rate code; 7 = single step |
| hwMode | input | 1 | 1: setpoint change triggers; 0: GO triggers |
| goBit | input | 1 | Software start request |
| tick | input | 1 | Prescaled time-base strobe |
| dacCode | output | 6 | Present DAC code |
| busy | output | 1 | A ramp is in progress |
| done | output | 1 | One-clock pulse when the target is reached |

## Verification
The hardest case to reach is a re-trigger that lands part-way through a ramp. It needs hardware mode and a slow enough rate to leave a window, and the new target must be raised on a known cycle. The bench runs a 4-tick-per-step ramp and raises the setpoint on the fifth clock after the trigger. It then checks that the code never drops and that the completion time includes exactly one skipped count. Holding tick low during a ramp separately shows that progress depends on the time base and not on the clock.

// File: rtl/slew_seq_pkg.sv
package slew_seq_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic latchTgt;  // capture targetCode as the destination
    logic jump;      // load targetCode into the DAC code directly
    logic step;      // advance the DAC code by one
  } seqStrobe_t;
endpackage

// File: rtl/slew_seq_datapath.sv
module slew_seq_datapath
  import slew_seq_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int RST_CODE = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] targetCode,
  input  seqStrobe_t        strb,
  output logic [CODE_W-1:0] dacCode,
  output logic [CODE_W-1:0] tgtCode,
  output logic              newAbove,
  output logic              lastStep
);
  localparam logic [CODE_W-1:0] ONE_CODE = CODE_W'(1);
  localparam logic [CODE_W-1:0] INIT     = CODE_W'(RST_CODE);

  logic [CODE_W-1:0] nextUp;

  always_comb begin
    nextUp   = dacCode + ONE_CODE;
    newAbove = targetCode > dacCode;
    lastStep = nextUp == tgtCode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dacCode <= INIT;
      tgtCode <= INIT;
    end else begin
      if (strb.latchTgt) tgtCode <= targetCode;
      if (strb.jump)      dacCode <= targetCode;
      else if (strb.step) dacCode <= nextUp;
    end
  end
endmodule

// File: rtl/slew_seq_ctrl.sv
module slew_seq_ctrl
  import slew_seq_pkg::*;
#(
  parameter int CODE_W     = 6,
  parameter int RATE_W     = 3,
  parameter int BASE_SHIFT = 6,
  parameter int RST_CODE   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] targetCode,
  input  logic [RATE_W-1:0] slewCode,
  input  logic              hwMode,
  input  logic              goBit,
  input  logic              tick,
  input  logic              newAbove,
  input  logic              lastStep,
  output seqStrobe_t        strb,
  output logic              busy,
  output logic              done
);
  localparam int CNT_W = BASE_SHIFT + 1;
  localparam logic [RATE_W-1:0] SINGLE_CODE = {RATE_W{1'b1}};
  localparam logic [CNT_W-1:0]  CNT_ONE     = CNT_W'(1);

  logic              goPrev;
  logic [CODE_W-1:0] tgtPrev;
  logic [CNT_W-1:0]  tickCnt;
  logic [CNT_W-1:0]  stepLimit;
  logic              trig, rampOk, atLimit, stepNow, finish;

  always_comb begin
    if (slewCode == SINGLE_CODE) stepLimit = CNT_ONE;
    else stepLimit = CNT_ONE << (BASE_SHIFT - int'(slewCode));
    trig    = hwMode ? (targetCode != tgtPrev) : (goBit & ~goPrev);
    rampOk  = newAbove && (slewCode != SINGLE_CODE);
    atLimit = tickCnt >= (stepLimit - CNT_ONE);
    stepNow = busy && !trig && tick && atLimit;
    finish  = stepNow && lastStep;
    strb.latchTgt = trig;
    strb.jump     = trig && !rampOk;
    strb.step     = stepNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      goPrev  <= 1'b0;
      tgtPrev <= CODE_W'(RST_CODE);
      tickCnt <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      goPrev  <= goBit;
      tgtPrev <= targetCode;
      done    <= (trig && !rampOk) || finish;
      if (trig)        busy <= rampOk;
      else if (finish) busy <= 1'b0;
      if (trig && !busy)              tickCnt <= '0;
      else if (busy && tick && !trig) tickCnt <= atLimit ? '0 : tickCnt + CNT_ONE;
    end
  end
endmodule

// File: rtl/slew_sequencer.sv
module slew_sequencer
  import slew_seq_pkg::*;
#(
  parameter int CODE_W     = 6,
  parameter int RATE_W     = 3,
  parameter int BASE_SHIFT = 6,
  parameter int RST_CODE   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] targetCode,
  input  logic [RATE_W-1:0] slewCode,
  input  logic              hwMode,
  input  logic              goBit,
  input  logic              tick,
  output logic [CODE_W-1:0] dacCode,
  output logic              busy,
  output logic              done
);
  seqStrobe_t        strb;
  logic [CODE_W-1:0] latchedTarget;
  logic              newAbove, lastStep;

  slew_seq_ctrl #(
    .CODE_W(CODE_W), .RATE_W(RATE_W), .BASE_SHIFT(BASE_SHIFT), .RST_CODE(RST_CODE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .targetCode(targetCode), .slewCode(slewCode),
    .hwMode(hwMode), .goBit(goBit), .tick(tick), .newAbove(newAbove),
    .lastStep(lastStep), .strb(strb), .busy(busy), .done(done)
  );

  slew_seq_datapath #(
    .CODE_W(CODE_W), .RST_CODE(RST_CODE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .targetCode(targetCode), .strb(strb),
    .dacCode(dacCode), .tgtCode(latchedTarget), .newAbove(newAbove),
    .lastStep(lastStep)
  );
endmodule

// File: rtl/slew_sequencer_chk.sv
module slew_sequencer_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              busy,
  input logic              done,
  input logic [CODE_W-1:0] dacCode,
  input logic [CODE_W-1:0] tgtCode
);
  // R10: a running ramp only holds or climbs by one
  p_climb_by_one_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!busy || dacCode == $past(dacCode) || dacCode == $past(dacCode) + CODE_W'(1)));

  // R10: no tick, no movement
  p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !tick) |=> (!busy || $stable(dacCode)));

  // R7: done only when the destination is reached, never with busy
  p_done_at_target_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (dacCode == tgtCode && !busy));

  // R7: busy only drops together with done
  p_busy_fall_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R4: while ramping the destination is strictly above the code
  p_ramp_below_target_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> tgtCode > dacCode);
endmodule

bind slew_sequencer slew_sequencer_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .busy(busy), .done(done),
  .dacCode(dacCode), .tgtCode(latchedTarget)
);

// File: tb/slew_sequencer_test.sv
module slew_sequencer_test;
  logic       clk = 1'b0;
  logic       rstN;
  logic [5:0] targetCode;
  logic [2:0] slewCode;
  logic       hwMode, goBit, tick;
  logic [5:0] dacCode;
  logic       busy, done;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  slew_sequencer uut (
    .clk(clk), .rstN(rstN), .targetCode(targetCode), .slewCode(slewCode),
    .hwMode(hwMode), .goBit(goBit), .tick(tick), .dacCode(dacCode),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Waits for done. n counts negedges since the trigger edge (1 = just after it).
  // Also checks the one-clock width of done, busy low with it, monotonic climb.
  task automatic wait_done(output int n, output bit sawBusy, output bit monoOk,
                           input int retrigAt, input logic [5:0] retrigVal);
    logic [5:0] prev;
    prev = dacCode;
    n = 0; sawBusy = 0; monoOk = 1;
    for (int i = 1; i <= 600; i++) begin
      @(negedge clk);
      n = i;
      if (busy) sawBusy = 1;
      if (busy && dacCode < prev) monoOk = 0;
      prev = dacCode;
      if (done) break;
      if (i == retrigAt) targetCode = retrigVal;
    end
    check(done == 1'b1 && busy == 1'b0, "R7 done with busy low", {busy, done}, 1);
    @(negedge clk);
    check(done == 1'b0, "R7 done one clock wide", done, 0);
  endtask

  task automatic sw_move(input logic [5:0] tgt, input logic [2:0] r, input int expN,
                         input bit expBusy, input string tag);
    int n; bit sb, mono;
    hwMode = 0; slewCode = r; targetCode = tgt; goBit = 1;
    wait_done(n, sb, mono, -1, 6'd0);
    goBit = 0;
    check(n == expN, tag, n, expN);
    check(dacCode == tgt, tag, dacCode, tgt);
    check(sb == expBusy, tag, sb, expBusy);
    check(mono, "R10 climb monotonic", 0, 1);
    @(negedge clk);
  endtask

  task automatic test_reset;
    check(dacCode == 6'd0, "R1 reset code", dacCode, 0);
    check(busy == 1'b0, "R1 reset busy", busy, 0);
    check(done == 1'b0, "R1 reset done", done, 0);
  endtask

  task automatic test_sw_ignores_target;
    // R2: in software mode a setpoint change alone does nothing
    bit any = 0;
    logic [5:0] start = dacCode;
    hwMode = 0; goBit = 0; targetCode = start + 6'd9;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (busy || done || dacCode != start) any = 1;
    end
    check(!any, "R2 target change ignored in sw mode", any, 0);
  endtask

  task automatic test_hw_ignores_go;
    // R3: in hardware mode GO does nothing
    bit any = 0;
    logic [5:0] start = dacCode;
    hwMode = 0; targetCode = start + 6'd5; @(negedge clk); @(negedge clk);
    hwMode = 1; @(negedge clk);
    goBit = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (busy || done || dacCode != start) any = 1;
    end
    goBit = 0; @(negedge clk);
    check(!any, "R3 GO ignored in hw mode", any, 0);
  endtask

  task automatic test_hw_move;
    // R3/R4: setpoint change triggers; rate 5 -> 2 ticks per step
    int n; bit sb, mono;
    logic [5:0] start = dacCode;
    hwMode = 1; slewCode = 3'd5; targetCode = start + 6'd3;
    wait_done(n, sb, mono, -1, 6'd0);
    check(n == 3 * 2 + 1, "R3 hw trigger timing", n, 7);
    check(dacCode == start + 6'd3, "R3 hw final code", dacCode, start + 6'd3);
    @(negedge clk);
  endtask

  task automatic test_retrigger;
    // R9: rate 4 (4 ticks/step), re-raise at clock 5, one skipped count
    int n; bit sb, mono;
    logic [5:0] start = dacCode;
    hwMode = 1; slewCode = 3'd4; targetCode = start + 6'd3;
    wait_done(n, sb, mono, 5, start + 6'd8);
    check(n == 8 * 4 + 2, "R9 retrigger timing", n, 34);
    check(dacCode == start + 6'd8, "R9 retrigger final", dacCode, start + 6'd8);
    check(mono, "R9 no drop on retrigger", 0, 1);
    @(negedge clk);
  endtask

  task automatic test_no_tick;
    // R10: no tick holds the ramp
    int n; bit sb, mono;
    bit moved = 0;
    logic [5:0] start = dacCode;
    hwMode = 0; slewCode = 3'd6; tick = 0; targetCode = start + 6'd4; goBit = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (dacCode != start) moved = 1;
    end
    check(busy == 1'b1, "R10 busy while stalled", busy, 1);
    check(!moved, "R10 held without tick", dacCode, start);
    tick = 1;
    wait_done(n, sb, mono, -1, 6'd0);
    check(n == 4, "R10 resumes on tick", n, 4);
    goBit = 0;
    @(negedge clk);
  endtask

  initial begin
    rstN = 0; targetCode = 0; slewCode = 3'd7; hwMode = 0; goBit = 0; tick = 1;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    test_reset();
    sw_move(6'd10, 3'd6, 10 * 1 + 1, 1, "R2 R4 rate6 ramp");
    sw_move(6'd12, 3'd0, 2 * 64 + 1, 1, "R4 rate0 ramp");
    sw_move(6'd17, 3'd3, 5 * 8 + 1, 1, "R4 rate3 ramp");
    sw_move(6'd40, 3'd7, 1, 0, "R5 single step rise");
    sw_move(6'd5, 3'd0, 1, 0, "R6 falling single step");
    sw_move(6'd5, 3'd2, 1, 0, "R8 equal target");
    test_sw_ignores_target();
    test_hw_ignores_go();
    test_hw_move();
    test_retrigger();
    test_no_tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule